// File: doc/BRIEF.md
# Frame Edge Delay Meter

This block time-stamps a rising edge on one of several frame measurement inputs against the device's own frame position. It lets a controller find out how late a line's frame starts compared with the local frame. The result is then used elsewhere to set delay compensation. The controller issues a command that carries an input index. The block arms itself and waits for the next rising edge on that input. It then stores the frame position at which the edge was first seen. The stored value has half-clock resolution, because each input is sampled on both clock edges.

The block keeps its own frame position counter. The counter restarts at every rising edge of the frame sync input. A measurement can only be armed after the first such sync has been seen. The block holds the result until it is read. The result leaves the block as a one-word valid/ready stream: `res_valid` rises when a capture completes and acts as the completion interrupt. `res_data` stays frozen while `res_valid` is high and `res_ready` is low. The word is consumed on the clock edge at which both are high. The command pins and the `busy` and `synced` status pins are plain level signals with no handshake.

Top module: `frame_edge_meter`

## Requirements
- R1: After reset, `busy`, `synced` and `res_valid` are 0 and `res_data` is 0.
- R2: `synced` goes to 1 on the first clock edge that samples `frame_sync` high after it was sampled low, and then stays at 1. Until then, every command is ignored.
- R3: The position counter N is 0 in the cycle that follows a clock edge at which a rising `frame_sync` was sampled. It then rises by one per clock and wraps from FRAME_CLKS-1 to 0. A new sync restarts it from 0 at any point in the frame.
- R4: A command (`cmd_go` high at a clock edge) with a valid index, taken while the block is idle and synced, makes `busy` read 1 from the next cycle on.
- R5: The captured value is 2·N for an edge first seen at the rising-edge sample that opens cycle N. It is 2·N+1 for an edge first seen at the falling-edge sample in the middle of cycle N. Bit 0 is the half-clock flag and the upper bits hold N.
- R6: Only the first rising edge on the selected input after the command is captured. Later edges leave `res_data` unchanged. An input that is already high when the command is taken must first go low and then rise again before it is captured.
- R7: A command issued while `busy` is 1, or while an unread result is pending, is ignored. The armed input stays the same.
- R8: A command whose index is NUM_IN or larger is ignored.
- R9: `res_valid` stays at 1, with `res_data` stable, until a clock edge sees `res_ready` high. In the next cycle `res_valid` is 0. `res_ready` has no effect while `res_valid` is 0.
- R10: `busy` falls in the same cycle that `res_valid` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock; inputs are sampled on both edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Frame sync; a rising edge restarts the position counter |
| meas_in | input | NUM_IN | Frame measurement inputs |
| cmd_go | input | 1 | Command strobe, one clock per command |
| cmd_sel | input | SEL_W | Index of the input to measure |
| busy | output | 1 | Measurement armed and waiting for an edge |
| synced | output | 1 | A frame sync has been seen since reset |
| res_valid | output | 1 | Result pending; also the completion interrupt |
| res_ready | input | 1 | Result consumer ready; a handshake clears `res_valid` |
| res_data | output | CNT_W+1 | Captured half-clock frame position |

## Verification
The hardest case to reach from the ports is the choice between the two samples within a single clock. The result depends on whether a rising input is caught first by the falling-edge sample or by the rising-edge sample. The bench therefore changes the measurement input either just after a rising edge or just after a falling edge, and predicts 2·N+1 or 2·N from its own frame position model. A second case that is hard to reach is a capture that lands exactly on the frame wrap. The bench runs with a short frame, waits until its model reaches the last position, arms the block and raises the input in the first half of position 0.

// File: rtl/frame_edge_pkg.sv
package frame_edge_pkg;

  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_ARMED = 2'd1,
    MS_DONE  = 2'd2
  } meas_state_e;

endpackage

// File: rtl/frame_edge_pos_counter.sv
module frame_edge_pos_counter #(
  parameter int FRAME_CLKS = 2048,
  localparam int CNT_W = $clog2(FRAME_CLKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_sync,
  output logic [CNT_W-1:0] pos_cnt,
  output logic             synced
);

  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_CLKS - 1);

  logic sync_q;
  logic sync_rise;

  assign sync_rise = frame_sync && !sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      synced  <= 1'b0;
      pos_cnt <= '0;
    end else begin
      sync_q <= frame_sync;
      if (sync_rise) begin
        pos_cnt <= '0;
        synced  <= 1'b1;
      end else if (pos_cnt == LAST_POS) begin
        pos_cnt <= '0;
      end else begin
        pos_cnt <= pos_cnt + 1'b1;
      end
    end
  end

  assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_cnt == LAST_POS && !sync_rise) |=> pos_cnt == '0);

  assert_sync_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && !sync_q) |=> pos_cnt == '0);

  assert_synced_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    synced |=> synced);

endmodule

// File: rtl/frame_edge_sampler.sv
module frame_edge_sampler #(
  parameter int NUM_IN = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] meas_in,
  output logic [NUM_IN-1:0] rise_smp,
  output logic [NUM_IN-1:0] fall_smp,
  output logic [NUM_IN-1:0] prev_fall_smp
);

  for (genvar g = 0; g < NUM_IN; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rise_smp[g]      <= 1'b0;
        prev_fall_smp[g] <= 1'b0;
      end else begin
        rise_smp[g]      <= meas_in[g];
        prev_fall_smp[g] <= fall_smp[g];
      end
    end

    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fall_smp[g] <= 1'b0;
      end else begin
        fall_smp[g] <= meas_in[g];
      end
    end
  end

endmodule

// File: rtl/frame_edge_capture.sv
module frame_edge_capture
  import frame_edge_pkg::*;
#(
  parameter int NUM_IN = 6,
  parameter int CNT_W  = 11,
  parameter int SEL_W  = 3,
  localparam int RES_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              synced,
  input  logic [CNT_W-1:0]  pos_cnt,
  input  logic [NUM_IN-1:0] rise_smp,
  input  logic [NUM_IN-1:0] fall_smp,
  input  logic [NUM_IN-1:0] prev_fall_smp,
  input  logic              cmd_go,
  input  logic [SEL_W-1:0]  cmd_sel,
  output logic              busy,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [RES_W-1:0]  res_data
);

  localparam logic [SEL_W:0] SEL_LIMIT = (SEL_W + 1)'(NUM_IN);

  meas_state_e      state_q;
  logic [SEL_W-1:0] sel_q;
  logic [RES_W-1:0] res_q;
  logic             pick_prev, pick_rise, pick_fall;
  logic             edge_at_rise, edge_at_fall, hit, sel_ok, cmd_take;

  always_comb begin
    pick_prev = 1'b0;
    pick_rise = 1'b0;
    pick_fall = 1'b0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (sel_q == SEL_W'(i)) begin
        pick_prev = prev_fall_smp[i];
        pick_rise = rise_smp[i];
        pick_fall = fall_smp[i];
      end
    end
  end

  assign edge_at_rise = !pick_prev && pick_rise;
  assign edge_at_fall = !pick_rise && pick_fall;
  assign hit          = (state_q == MS_ARMED) && (edge_at_rise || edge_at_fall);
  assign sel_ok       = {1'b0, cmd_sel} < SEL_LIMIT;
  assign cmd_take     = cmd_go && sel_ok && synced && (state_q == MS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
      sel_q   <= '0;
      res_q   <= '0;
    end else begin
      unique case (state_q)
        MS_IDLE: if (cmd_take) begin
          state_q <= MS_ARMED;
          sel_q   <= cmd_sel;
        end
        MS_ARMED: if (hit) begin
          state_q <= MS_DONE;
          res_q   <= {pos_cnt, edge_at_fall};
        end
        MS_DONE: if (res_ready) begin
          state_q <= MS_IDLE;
        end
        default: state_q <= MS_IDLE;
      endcase
    end
  end

  assign busy      = (state_q == MS_ARMED);
  assign res_valid = (state_q == MS_DONE);
  assign res_data  = res_q;

  assert_no_arm_unsynced_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!synced && !busy) |=> !busy);

  assert_bad_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MS_IDLE && cmd_go && !sel_ok) |=> !busy);

  assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sel_q));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  assert_handshake_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> !res_valid);

  assert_done_follows_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> ($past(busy) && !busy));

endmodule

// File: rtl/frame_edge_meter.sv
module frame_edge_meter #(
  parameter int NUM_IN     = 6,
  parameter int FRAME_CLKS = 2048,
  localparam int SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int CNT_W = $clog2(FRAME_CLKS),
  localparam int RES_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic [NUM_IN-1:0] meas_in,
  input  logic              cmd_go,
  input  logic [SEL_W-1:0]  cmd_sel,
  output logic              busy,
  output logic              synced,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [RES_W-1:0]  res_data
);

  logic [CNT_W-1:0]  pos_cnt;
  logic [NUM_IN-1:0] rise_smp, fall_smp, prev_fall_smp;

  frame_edge_pos_counter #(
    .FRAME_CLKS (FRAME_CLKS)
  ) u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .pos_cnt    (pos_cnt),
    .synced     (synced)
  );

  frame_edge_sampler #(
    .NUM_IN (NUM_IN)
  ) u_smp (
    .clk           (clk),
    .rst_n         (rst_n),
    .meas_in       (meas_in),
    .rise_smp      (rise_smp),
    .fall_smp      (fall_smp),
    .prev_fall_smp (prev_fall_smp)
  );

  frame_edge_capture #(
    .NUM_IN (NUM_IN),
    .CNT_W  (CNT_W),
    .SEL_W  (SEL_W)
  ) u_cap (
    .clk           (clk),
    .rst_n         (rst_n),
    .synced        (synced),
    .pos_cnt       (pos_cnt),
    .rise_smp      (rise_smp),
    .fall_smp      (fall_smp),
    .prev_fall_smp (prev_fall_smp),
    .cmd_go        (cmd_go),
    .cmd_sel       (cmd_sel),
    .busy          (busy),
    .res_valid     (res_valid),
    .res_ready     (res_ready),
    .res_data      (res_data)
  );

endmodule

// File: tb/frame_edge_meter_bench.sv
`timescale 1ns/1ps
module frame_edge_meter_bench;

  localparam int NUM_IN = 6;
  localparam int FRAME  = 64;
  localparam int SEL_W  = 3;
  localparam int RES_W  = $clog2(FRAME) + 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             frame_sync = 1'b0;
  logic [NUM_IN-1:0] meas_in = '0;
  logic             cmd_go = 1'b0;
  logic [SEL_W-1:0] cmd_sel = '0;
  logic             res_ready = 1'b0;
  logic             busy, synced, res_valid;
  logic [RES_W-1:0] res_data;

  int n_chk = 0;
  int n_err = 0;
  int expv;

  always #2.5 clk = ~clk;

  frame_edge_meter #(.NUM_IN(NUM_IN), .FRAME_CLKS(FRAME)) u_frame_edge_meter (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .meas_in(meas_in),
    .cmd_go(cmd_go), .cmd_sel(cmd_sel), .busy(busy), .synced(synced),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  // Behavioural reference model
  int m_cnt = 0, m_sel = 0, m_data = 0;
  bit m_sync_prev = 0, m_synced = 0, m_busy = 0, m_rv = 0;
  bit [NUM_IN-1:0] m_ps = '0, m_ns = '0, m_lastn = '0;

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) m_ns <= '0;
    else        m_ns <= meas_in;
  end

  always @(posedge clk) begin
    bit cap, half, ob, orv, osy;
    if (!rst_n) begin
      m_cnt = 0; m_sel = 0; m_data = 0; m_sync_prev = 0; m_synced = 0;
      m_busy = 0; m_rv = 0; m_ps = '0; m_lastn = '0;
    end else begin
      cap = 0; half = 0;
      ob = m_busy; orv = m_rv; osy = m_synced;
      if (m_busy) begin
        if (!m_lastn[m_sel] && m_ps[m_sel]) cap = 1;
        else if (!m_ps[m_sel] && m_ns[m_sel]) begin cap = 1; half = 1; end
      end
      if (m_rv && res_ready) m_rv = 0;
      if (cap) begin m_busy = 0; m_rv = 1; m_data = 2 * m_cnt + int'(half); end
      if (cmd_go && !ob && !orv && osy && int'(cmd_sel) < NUM_IN) begin
        m_busy = 1; m_sel = int'(cmd_sel);
      end
      m_lastn = m_ns;
      m_ps = meas_in;
      if (frame_sync && !m_sync_prev) begin m_cnt = 0; m_synced = 1; end
      else m_cnt = (m_cnt + 1) % FRAME;
      m_sync_prev = frame_sync;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == m_busy, "R4 busy vs model", int'(busy), int'(m_busy));
      chk(synced == m_synced, "R2 synced vs model", int'(synced), int'(m_synced));
      chk(res_valid == m_rv, "R9 res_valid vs model", int'(res_valid), int'(m_rv));
      chk(int'(res_data) == m_data, "R5 res_data vs model", int'(res_data), m_data);
    end
  end

  task automatic send_cmd(input int s);
    @(negedge clk); #1 cmd_go = 1'b1; cmd_sel = SEL_W'(s);
    @(negedge clk); #1 cmd_go = 1'b0;
  endtask

  task automatic do_sync();
    @(negedge clk); #1 frame_sync = 1'b1;
    @(negedge clk); #1 frame_sync = 1'b0;
  endtask

  task automatic read_res();
    @(negedge clk); #1 res_ready = 1'b1;
    @(negedge clk); #1 res_ready = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!busy && !res_valid && !synced, "R1 flags after reset", int'({busy, res_valid, synced}), 0);
    chk(res_data == '0, "R1 data after reset", int'(res_data), 0);

    // R2: commands ignored before the first sync
    send_cmd(1);
    wait_cyc(2);
    chk(!busy, "R2 command before sync", int'(busy), 0);
    meas_in[1] = 1'b1; wait_cyc(2); meas_in[1] = 1'b0; wait_cyc(2);
    chk(!res_valid, "R2 no result before sync", int'(res_valid), 0);

    // R5: edge seen at the rising-edge sample
    do_sync();
    chk(synced, "R2 synced after sync", int'(synced), 1);
    send_cmd(2);
    chk(busy, "R4 busy after command", int'(busy), 1);
    repeat (3) @(negedge clk);
    #1 expv = 2 * ((m_cnt + 1) % FRAME); meas_in[2] = 1'b1;
    wait_cyc(3);
    chk(res_valid && !busy, "R10 busy falls as valid rises", int'({busy, res_valid}), 1);
    chk(int'(res_data) == expv, "R5 rising-sample value", int'(res_data), expv);
    chk(res_data[0] == 1'b0, "R5 half flag clear", int'(res_data[0]), 0);

    // R6: later edges ignored; R7: command while pending ignored
    meas_in[2] = 1'b0; wait_cyc(2); meas_in[2] = 1'b1; wait_cyc(3);
    chk(int'(res_data) == expv, "R6 later edge ignored", int'(res_data), expv);
    send_cmd(3);
    wait_cyc(2);
    chk(!busy, "R7 command while result pending", int'(busy), 0);

    // R9: result held until handshake
    wait_cyc(5);
    chk(res_valid, "R9 valid held without ready", int'(res_valid), 1);
    read_res();
    chk(!res_valid, "R9 valid cleared by handshake", int'(res_valid), 0);

    // R5: edge seen at the falling-edge sample
    send_cmd(4);
    repeat (2) @(negedge clk);
    @(posedge clk); #1 expv = 2 * m_cnt + 1; meas_in[4] = 1'b1;
    wait_cyc(3);
    chk(int'(res_data) == expv, "R5 falling-sample value", int'(res_data), expv);
    chk(res_data[0] == 1'b1, "R5 half flag set", int'(res_data[0]), 1);
    read_res();

    // R6: input already high when armed
    send_cmd(4);
    wait_cyc(5);
    chk(busy && !res_valid, "R6 high level is not an edge", int'({busy, res_valid}), 2);
    meas_in[4] = 1'b0;
    @(negedge clk); #1 expv = 2 * ((m_cnt + 1) % FRAME); meas_in[4] = 1'b1;
    wait_cyc(3);
    chk(int'(res_data) == expv, "R6 fall then rise captured", int'(res_data), expv);
    read_res();

    // R7: command while busy ignored, armed input kept
    send_cmd(0);
    send_cmd(5);
    meas_in[5] = 1'b1;
    wait_cyc(4);
    chk(busy && !res_valid, "R7 other input ignored while busy", int'({busy, res_valid}), 2);
    @(negedge clk); #1 expv = 2 * ((m_cnt + 1) % FRAME); meas_in[0] = 1'b1;
    wait_cyc(3);
    chk(int'(res_data) == expv, "R7 armed input captured", int'(res_data), expv);
    read_res();

    // R8: out-of-range indices ignored
    send_cmd(6);
    wait_cyc(2);
    chk(!busy, "R8 index 6 ignored", int'(busy), 0);
    send_cmd(7);
    wait_cyc(2);
    chk(!busy, "R8 index 7 ignored", int'(busy), 0);

    // R3: capture on the frame wrap
    send_cmd(1);
    while (m_cnt != FRAME - 2) @(negedge clk);
    @(negedge clk);
    @(posedge clk); #1 meas_in[1] = 1'b1;
    wait_cyc(3);
    chk(int'(res_data) == 1, "R3 wrap to position zero", int'(res_data), 1);
    read_res();

    // R3: resync in mid-frame restarts the counter
    wait_cyc(10);
    do_sync();
    send_cmd(3);
    @(posedge clk); #1 meas_in[3] = 1'b1;
    wait_cyc(3);
    chk(int'(res_data) == 7, "R3 restart by mid-frame sync", int'(res_data), 7);
    read_res();
    wait_cyc(3);

    finish_run();
  end

endmodule